// File: doc/BRIEF.md
# Literal-Operand ALU with Working Register

This block carries out the immediate-operand group of an 8-bit processor's instruction set against a single working register. Every instruction is 16 bits wide. The upper byte selects the operation and the lower byte is the literal operand. Supported operations are load, add, subtract (literal minus working register), AND, inclusive OR, exclusive OR and unsigned multiply. Each operation updates its own set of the overflow, carry, digit-carry and zero flags and leaves the other flags alone.

An instruction is presented together with a one-cycle valid strobe. The block can accept a new instruction on every clock. The register file, the flags and the separate 16-bit product register take their new values on the edge that accepts the instruction. Cycles with no valid strobe, and opcodes outside the group, leave all state as it is.

Top module: `lit_alu`

## Requirements
- R1: While reset is asserted (rstN low), and afterwards until the first accepted instruction, the working register, all four flags and the product are zero.
- R2: Upper byte 0xB0 loads the literal into the working register. All flags and the product stay unchanged.
- R3: Upper byte 0xB1 sets the working register to (W + literal) mod 256. C is the carry out of bit 7 and DC is the carry out of bit 3. OV is set on signed overflow and Z is set when the result is zero.
- R4: Upper byte 0xB2 sets the working register to (literal − W) mod 256. C is 1 when no borrow occurs, i.e. literal ≥ W unsigned. DC is 1 when the low nibble produces no borrow (literal[3:0] ≥ W[3:0]). OV is set on signed overflow and Z is set on a zero result.
- R5: Upper bytes 0xB5 (AND), 0xB3 (OR) and 0xB4 (XOR) write the bitwise result to the working register and set Z from it. OV, C and DC stay unchanged.
- R6: Upper byte 0xBC places the unsigned 16-bit product of the literal and W on the product output. The working register and all flags stay unchanged.
- R7: Each instruction completes in one cycle. Its results are visible just after the clock edge that samples it with opValid high, and instructions may follow each other on consecutive cycles.
- R8: A cycle with opValid low, or with an upper byte outside the codes listed in R2 to R6, changes neither the working register, nor any flag, nor the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Instruction strobe |
| opcode | input | 16 | Operation code in bits 15:8, literal in bits 7:0 |
| wreg | output | 8 | Working register |
| flagOv | output | 1 | Signed overflow flag |
| flagC | output | 1 | Carry / no-borrow flag |
| flagDc | output | 1 | Digit carry / no-borrow from bit 3 |
| flagZ | output | 1 | Zero flag |
| product | output | 16 | Result of the last multiply |

## Verification
Every result is due exactly one clock edge after the instruction is sampled, with no further pipeline stage. The bench drives an instruction on the falling edge and records the expected register, flag and product values from its own arithmetic model in a queue. It compares them shortly after the next rising edge. Runs of back-to-back instructions check that each result depends on the one before it. Idle cycles and codes outside the group are scored at that same edge as "nothing changed".

// File: rtl/lit_alu_pkg.sv
package lit_alu_pkg;

  localparam logic [7:0] OPC_LOAD = 8'hB0;
  localparam logic [7:0] OPC_ADD  = 8'hB1;
  localparam logic [7:0] OPC_SUB  = 8'hB2;
  localparam logic [7:0] OPC_OR   = 8'hB3;
  localparam logic [7:0] OPC_XOR  = 8'hB4;
  localparam logic [7:0] OPC_AND  = 8'hB5;
  localparam logic [7:0] OPC_MUL  = 8'hBC;

  typedef enum logic [2:0] {
    SEL_PASS,
    SEL_ARITH,
    SEL_AND,
    SEL_OR,
    SEL_XOR
  } aluSel_e;

  typedef struct packed {
    aluSel_e sel;
    logic    subMode;
    logic    wrW;
    logic    wrArith;
    logic    wrZero;
    logic    wrProd;
  } aluCtl_t;

endpackage

// File: rtl/lit_alu_ctrl.sv
module lit_alu_ctrl
  import lit_alu_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic            opValid,
  input  logic [HI_W-1:0] opHigh,
  output aluCtl_t         ctl
);

  always_comb begin
    ctl = '{sel: SEL_PASS, subMode: 1'b0, wrW: 1'b0, wrArith: 1'b0,
            wrZero: 1'b0, wrProd: 1'b0};
    if (opValid) begin
      unique case (opHigh)
        HI_W'(OPC_LOAD): begin
          ctl.sel = SEL_PASS;
          ctl.wrW = 1'b1;
        end
        HI_W'(OPC_ADD): begin
          ctl.sel     = SEL_ARITH;
          ctl.wrW     = 1'b1;
          ctl.wrArith = 1'b1;
          ctl.wrZero  = 1'b1;
        end
        HI_W'(OPC_SUB): begin
          ctl.sel     = SEL_ARITH;
          ctl.subMode = 1'b1;
          ctl.wrW     = 1'b1;
          ctl.wrArith = 1'b1;
          ctl.wrZero  = 1'b1;
        end
        HI_W'(OPC_AND): begin
          ctl.sel    = SEL_AND;
          ctl.wrW    = 1'b1;
          ctl.wrZero = 1'b1;
        end
        HI_W'(OPC_OR): begin
          ctl.sel    = SEL_OR;
          ctl.wrW    = 1'b1;
          ctl.wrZero = 1'b1;
        end
        HI_W'(OPC_XOR): begin
          ctl.sel    = SEL_XOR;
          ctl.wrW    = 1'b1;
          ctl.wrZero = 1'b1;
        end
        HI_W'(OPC_MUL): begin
          ctl.wrProd = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/lit_alu_dp.sv
module lit_alu_dp
  import lit_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  aluCtl_t             ctl,
  input  logic [DATA_W-1:0]   lit,
  output logic [DATA_W-1:0]   wreg,
  output logic                flagOv,
  output logic                flagC,
  output logic                flagDc,
  output logic                flagZ,
  output logic [2*DATA_W-1:0] product
);

  localparam int MSB    = DATA_W - 1;
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] wReg;
  logic [DATA_W-1:0] opB;
  logic [DATA_W:0]   fullSum;
  logic [NIB_W:0]    nibSum;
  logic [DATA_W-1:0] resVal;
  logic              ovNext;
  logic [PROD_W-1:0] prodNext;

  // subtraction is literal + ~W + 1, so carry out means "no borrow"
  assign opB     = ctl.subMode ? ~wReg : wReg;
  assign fullSum = {1'b0, lit} + {1'b0, opB} + (DATA_W+1)'(ctl.subMode);
  assign nibSum  = {1'b0, lit[NIB_W-1:0]} + {1'b0, opB[NIB_W-1:0]}
                 + (NIB_W+1)'(ctl.subMode);
  assign ovNext  = (lit[MSB] == opB[MSB]) && (fullSum[MSB] != lit[MSB]);
  assign prodNext = PROD_W'(lit) * PROD_W'(wReg);

  always_comb begin
    unique case (ctl.sel)
      SEL_ARITH: resVal = fullSum[DATA_W-1:0];
      SEL_AND:   resVal = lit & wReg;
      SEL_OR:    resVal = lit | wReg;
      SEL_XOR:   resVal = lit ^ wReg;
      default:   resVal = lit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wReg    <= '0;
      flagOv  <= 1'b0;
      flagC   <= 1'b0;
      flagDc  <= 1'b0;
      flagZ   <= 1'b0;
      product <= '0;
    end else begin
      if (ctl.wrW)    wReg <= resVal;
      if (ctl.wrZero) flagZ <= (resVal == '0);
      if (ctl.wrArith) begin
        flagOv <= ovNext;
        flagC  <= fullSum[DATA_W];
        flagDc <= nibSum[NIB_W];
      end
      if (ctl.wrProd) product <= prodNext;
    end
  end

  assign wreg = wReg;

endmodule

// File: rtl/lit_alu.sv
module lit_alu
  import lit_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [2*DATA_W-1:0] opcode,
  output logic [DATA_W-1:0]   wreg,
  output logic                flagOv,
  output logic                flagC,
  output logic                flagDc,
  output logic                flagZ,
  output logic [2*DATA_W-1:0] product
);

  localparam int OP_W = 2 * DATA_W;

  aluCtl_t ctl;

  lit_alu_ctrl #(.HI_W(DATA_W)) u_ctrl (
    .opValid (opValid),
    .opHigh  (opcode[OP_W-1:DATA_W]),
    .ctl     (ctl)
  );

  lit_alu_dp #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .lit     (opcode[DATA_W-1:0]),
    .wreg    (wreg),
    .flagOv  (flagOv),
    .flagC   (flagC),
    .flagDc  (flagDc),
    .flagZ   (flagZ),
    .product (product)
  );

endmodule

// File: rtl/lit_alu_chk.sv
module lit_alu_chk (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [15:0] opcode,
  input logic [7:0]  wreg,
  input logic        flagOv,
  input logic        flagC,
  input logic        flagDc,
  input logic        flagZ,
  input logic [15:0] product
);

  logic isLoad, isAdd, isSub, isLogic, isMul, isKnown;
  assign isLoad  = opValid && opcode[15:8] == 8'hB0;
  assign isAdd   = opValid && opcode[15:8] == 8'hB1;
  assign isSub   = opValid && opcode[15:8] == 8'hB2;
  assign isLogic = opValid && (opcode[15:8] == 8'hB3 || opcode[15:8] == 8'hB4
                               || opcode[15:8] == 8'hB5);
  assign isMul   = opValid && opcode[15:8] == 8'hBC;
  assign isKnown = isLoad || isAdd || isSub || isLogic || isMul;

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    isLoad |=> wreg == $past(opcode[7:0]) && $stable({flagOv, flagC, flagDc, flagZ})); // R2

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rstN)
    isAdd |=> wreg == 8'($past(opcode[7:0]) + $past(wreg))); // R3

  AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rstN)
    isSub |=> flagC == ($past(opcode[7:0]) >= $past(wreg))); // R4

  AST_LOGIC_KEEPS_ARITH: assert property (@(posedge clk) disable iff (!rstN)
    isLogic |=> $stable({flagOv, flagC, flagDc}) && flagZ == (wreg == 8'h00)); // R5

  AST_MUL_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    isMul |=> product == 16'($past(opcode[7:0])) * 16'($past(wreg)) && $stable(wreg)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !isKnown |=> $stable({wreg, flagOv, flagC, flagDc, flagZ, product})); // R8

endmodule

bind lit_alu lit_alu_chk u_chk (.*);

// File: tb/lit_alu_bench.sv
module lit_alu_bench;

  typedef struct {
    logic [7:0]  w;
    logic        ov, c, dc, z;
    logic [15:0] prod;
    string       req;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [15:0] opcode = '0;
  logic [7:0]  wreg;
  logic        flagOv, flagC, flagDc, flagZ;
  logic [15:0] product;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  logic [7:0]  mW = '0;
  logic        mOv = 0, mC = 0, mDc = 0, mZ = 0;
  logic [15:0] mProd = '0;

  always #5 clk = ~clk;

  lit_alu u_lit_alu (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode),
    .wreg(wreg), .flagOv(flagOv), .flagC(flagC), .flagDc(flagDc),
    .flagZ(flagZ), .product(product)
  );

  task automatic compare(input expItem_t e);
    checks++;
    if (wreg !== e.w || flagOv !== e.ov || flagC !== e.c || flagDc !== e.dc ||
        flagZ !== e.z || product !== e.prod) begin
      errors++;
      $display("FAIL %s: got w=%h ov=%b c=%b dc=%b z=%b p=%h, expected w=%h ov=%b c=%b dc=%b z=%b p=%h",
               e.req, wreg, flagOv, flagC, flagDc, flagZ, product,
               e.w, e.ov, e.c, e.dc, e.z, e.prod);
    end
  endtask

  // monitor: the result of an instruction driven at a falling edge is due at the next rising edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) compare(expQ.pop_front());
  end

  task automatic doOp(input logic vld, input logic [7:0] hi, input logic [7:0] lit,
                      input string req);
    expItem_t e;
    int a, b, r;
    @(negedge clk);
    opValid = vld;
    opcode  = {hi, lit};
    if (vld) begin
      case (hi)
        8'hB0: mW = lit;
        8'hB1: begin
          r   = int'(mW) + int'(lit);
          mC  = r > 255;
          mDc = (int'(mW[3:0]) + int'(lit[3:0])) > 15;
          a = int'($signed(mW)); b = int'($signed(lit));
          mOv = (a + b) > 127 || (a + b) < -128;
          mW  = r[7:0];
          mZ  = mW == 0;
        end
        8'hB2: begin
          r   = int'(lit) - int'(mW);
          mC  = lit >= mW;
          mDc = lit[3:0] >= mW[3:0];
          a = int'($signed(lit)); b = int'($signed(mW));
          mOv = (a - b) > 127 || (a - b) < -128;
          mW  = r[7:0];
          mZ  = mW == 0;
        end
        8'hB5: begin mW = mW & lit; mZ = mW == 0; end
        8'hB3: begin mW = mW | lit; mZ = mW == 0; end
        8'hB4: begin mW = mW ^ lit; mZ = mW == 0; end
        8'hBC: mProd = 16'(int'(mW) * int'(lit));
        default: ;
      endcase
    end
    e.w = mW; e.ov = mOv; e.c = mC; e.dc = mDc; e.z = mZ; e.prod = mProd; e.req = req;
    expQ.push_back(e);
  endtask

  initial begin
    expItem_t r0;
    repeat (3) @(negedge clk);
    r0.w = 0; r0.ov = 0; r0.c = 0; r0.dc = 0; r0.z = 0; r0.prod = 0; r0.req = "R1";
    compare(r0);                                   // R1 during reset
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compare(r0);                                   // R1 after release
    // R2 load
    doOp(1, 8'hB0, 8'h7F, "R2");
    // R3 add with signed overflow, then wrap to zero
    doOp(1, 8'hB1, 8'h01, "R3");
    doOp(1, 8'hB0, 8'hFF, "R2");
    doOp(1, 8'hB1, 8'h01, "R3");
    doOp(1, 8'hB0, 8'h38, "R2");
    doOp(1, 8'hB1, 8'h19, "R3");
    // R4 subtract: equal, borrow, signed overflow, nibble borrow
    doOp(1, 8'hB0, 8'h05, "R2");
    doOp(1, 8'hB2, 8'h05, "R4");
    doOp(1, 8'hB0, 8'h01, "R2");
    doOp(1, 8'hB2, 8'h00, "R4");
    doOp(1, 8'hB0, 8'h01, "R2");
    doOp(1, 8'hB2, 8'h80, "R4");
    doOp(1, 8'hB0, 8'h0F, "R2");
    doOp(1, 8'hB2, 8'h30, "R4");
    // R5 logic ops keep OV, C, DC
    doOp(1, 8'hB5, 8'h0F, "R5");
    doOp(1, 8'hB3, 8'hA0, "R5");
    doOp(1, 8'hB4, 8'hA0, "R5");
    doOp(1, 8'hB4, 8'h00, "R5");
    doOp(1, 8'hB5, 8'h00, "R5");
    // R6 multiply
    doOp(1, 8'hB0, 8'hFF, "R2");
    doOp(1, 8'hBC, 8'hFF, "R6");
    doOp(1, 8'hB0, 8'h0C, "R2");
    doOp(1, 8'hBC, 8'h0B, "R6");
    // R8 idle and unlisted codes
    doOp(0, 8'hB0, 8'h55, "R8");
    doOp(1, 8'hB7, 8'h12, "R8");
    doOp(1, 8'h00, 8'h00, "R8");
    doOp(0, 8'hBC, 8'h99, "R8");
    // R7 long back-to-back chain
    for (int i = 0; i < 40; i++) begin
      doOp(1, 8'hB1, 8'(i * 37 + 3), "R7");
      doOp(1, 8'hB2, 8'(i * 11), "R7");
      doOp(1, 8'hBC, 8'(i * 5 + 1), "R7");
    end
    @(negedge clk);
    opValid = 1'b0;
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule